// File: doc/BRIEF.md
# SDRAM Low-Power Sequencer

This block sits beside the normal-mode command logic of an SDRAM controller and takes over the command bus whenever the memory has to enter, stay in or leave a low-power state. A two-bit mode field picks power-down or self refresh. An idle-timeout field picks how long the memory must go without access requests before the sequencer lowers CKE. While it owns the bus it raises `busy`, and the normal-mode logic must issue nothing.

In power-down the memory does not refresh itself. A refresh tick from the controller's refresh timer therefore makes the sequencer wake the memory and issue an AUTO-REFRESH itself. An access request also wakes the memory. On wake-up the sequencer raises CKE, holds NOP for the exit time and, for memory kinds that need it, keeps CKE low for a minimum residency first.

Before self refresh the sequencer rewrites the extended mode register and then issues an AUTO-REFRESH. The extended mode register holds the partial-array, temperature and drive-strength settings. Only then does it drop CKE. Every wait in the block comes from one shared down-counter that is loaded on entry to a timed state.

Top module: `sdram_lp_seq`

## Requirements
- R1: After reset CKE is high, `busy` is low, `ba` and `addr` are zero and `cmd` is NOP. Command codes on `cmd` are: NOP=0, PRECHARGE ALL=1, MRS=2, AUTO-REFRESH=3, ACTIVE=4. The sequencer itself never drives ACTIVE.
- R2: Mode field 2'b10 selects power-down and 2'b01 selects self refresh. Values 2'b00 and 2'b11 select no low-power state, and the memory then stays awake indefinitely with `busy` low.
- R3: In power-down CKE is low, `busy` is high and `cmd` is NOP.
- R4: The entry timeout works as follows. `idle_sel`=2'b00 enters on the first idle cycle. 2'b01 enters after 64 consecutive idle cycles, and 2'b10 or 2'b11 after 128. Any access request restarts the count.
- R5: A refresh tick seen during power-down wakes the memory, because no self refresh runs there. The sequencer then issues AUTO-REFRESH after the exit hold and frees the bus TRFC cycles after that command.
- R6: The cycle in which CKE rises carries a NOP command with `busy` high.
- R7: After CKE rises the sequencer holds NOP for exactly TXP cycles on low-power DDR1 memory, or one cycle on other memory kinds, before any other command or the release of the bus.
- R8: Once CKE drops, it stays low for at least TCKE cycles on low-power DDR1 and DDR2 memory (one cycle on SDR), even when a request is already waiting.
- R9: Entry to self refresh runs NOP, then PRECHARGE ALL, MRS TRP cycles later, AUTO-REFRESH TMRD cycles after the MRS, and CKE low TRFC cycles after the AUTO-REFRESH. The MRS carries bank address 2 and `ext_mode_val` on `addr`.
- R10: In self refresh, refresh ticks have no effect: CKE stays low with NOP. An access request brings the memory out through the same exit hold as in R7.
- R11: When a refresh tick and an access request arrive in the same power-down cycle, the AUTO-REFRESH is issued first. The grant follows TRFC cycles later.
- R12: `busy` is high in every cycle the sequencer owns the bus, and every non-NOP command appears only while `busy` is high. `acc_gnt` equals `acc_req` whenever `busy` is low, and it is never high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_mode | input | 2 | Low-power mode select (2'b10 power-down, 2'b01 self refresh) |
| idle_sel | input | 2 | Entry timeout select |
| acc_req | input | 1 | Access request from the controller |
| ref_tick | input | 1 | Refresh-due pulse from the refresh timer |
| ext_mode_val | input | ADDR_W | Extended mode register value written before self refresh |
| cke | output | 1 | Clock enable to the memory |
| cmd | output | 3 | Command code driven by the sequencer |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| busy | output | 1 | Sequencer owns the command bus |
| acc_gnt | output | 1 | Access may proceed this cycle |

## Verification
The assertions check the following on every cycle:
- each CKE rise carries a NOP;
- each CKE fall comes with `busy` high;
- CKE stays low for at least the residency time;
- no command other than NOP comes within the exit hold;
- an MRS is always preceded by a PRECHARGE ALL in the same sequence;
- commands and grants keep to the `busy` ownership rule.

Some behaviours only the directed scenarios can show. These are the exact lengths of the 64- and 128-cycle idle windows and their restart on a request. They also include the spacing between the self-refresh commands, the refresh injected in response to a tick and its ordering ahead of a simultaneous request, and the insensitivity of self refresh to ticks.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;

   typedef enum logic [2:0] {
      CMD_NOP  = 3'd0,
      CMD_PALL = 3'd1,
      CMD_MRS  = 3'd2,
      CMD_AREF = 3'd3,
      CMD_ACT  = 3'd4
   } sd_cmd_e;

   typedef enum logic [3:0] {
      ST_NORM,
      ST_PD,
      ST_WAKE,
      ST_REF,
      ST_REF_WT,
      ST_SR_NOP,
      ST_SR_PALL,
      ST_SR_WRP,
      ST_SR_MRS,
      ST_SR_WMRD,
      ST_SR_AREF,
      ST_SR_WRFC,
      ST_SR
   } lp_state_e;

   localparam logic [1:0] LPM_SELF  = 2'b01;
   localparam logic [1:0] LPM_PDOWN = 2'b10;

   localparam int KIND_SDR    = 0;
   localparam int KIND_LPDDR1 = 1;
   localparam int KIND_DDR2   = 2;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdram_lp_timer.sv
module sdram_lp_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= load_val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/sdram_lp_idle.sv
module sdram_lp_idle #(
   parameter int IDLE_SHORT = 64,
   parameter int IDLE_LONG  = 128
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       track,
   input  logic       acc_req,
   input  logic [1:0] sel,
   output logic       met
);

   localparam int IW = $clog2(IDLE_LONG + 1);

   logic [IW-1:0] cnt;
   int            thr;

   initial begin
      assert (IDLE_SHORT > 0 && IDLE_SHORT < IDLE_LONG)
         else $error("idle windows must satisfy 0 < short < long");
   end

   always_comb begin
      case (sel)
         2'b00:   thr = 0;
         2'b01:   thr = IDLE_SHORT;
         default: thr = IDLE_LONG;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                      cnt <= '0;
      else if (!track || acc_req)      cnt <= '0;
      else if (int'(cnt) != IDLE_LONG) cnt <= cnt + 1'b1;
   end

   assign met = (int'(cnt) + 1) >= thr;

endmodule

// File: rtl/sdram_lp_fsm.sv
module sdram_lp_fsm
   import sdram_lp_pkg::*;
#(
   parameter int ADDR_W   = 13,
   parameter int BA_W     = 2,
   parameter int TMR_W    = 4,
   parameter int TXP_EFF  = 3,
   parameter int TCKE_EFF = 4,
   parameter int TRP      = 3,
   parameter int TMRD     = 2,
   parameter int TRFC     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        lp_mode,
   input  logic              acc_req,
   input  logic              ref_tick,
   input  logic [ADDR_W-1:0] ext_mode_val,
   input  logic              idle_met,
   input  logic              tmr_zero,
   output logic              tmr_load,
   output logic [TMR_W-1:0]  tmr_val,
   output logic              track,
   output logic              cke,
   output logic [2:0]        cmd,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr,
   output logic              busy,
   output logic              acc_gnt
);

   lp_state_e st, st_n;
   logic      ref_pend;
   logic      resid_ok;
   sd_cmd_e   cmd_e;

   // residency gate: one-cycle minimum needs no counter
   generate
      if (TCKE_EFF <= 1) begin : g_no_resid
         assign resid_ok = 1'b1;
      end else begin : g_resid
         assign resid_ok = tmr_zero;
      end
   endgenerate

   always_comb begin
      st_n = st;
      unique case (st)
         ST_NORM: begin
            if (!acc_req && idle_met) begin
               if (lp_mode == LPM_PDOWN)     st_n = ST_PD;
               else if (lp_mode == LPM_SELF) st_n = ST_SR_NOP;
            end
         end
         ST_PD: begin
            if (resid_ok && (acc_req || ref_pend || ref_tick || lp_mode != LPM_PDOWN))
               st_n = ST_WAKE;
         end
         ST_WAKE: begin
            if (tmr_zero) st_n = (ref_pend || ref_tick) ? ST_REF : ST_NORM;
         end
         ST_REF:     st_n = ST_REF_WT;
         ST_REF_WT:  if (tmr_zero) st_n = ST_NORM;
         ST_SR_NOP:  st_n = ST_SR_PALL;
         ST_SR_PALL: st_n = ST_SR_WRP;
         ST_SR_WRP:  if (tmr_zero) st_n = ST_SR_MRS;
         ST_SR_MRS:  st_n = ST_SR_WMRD;
         ST_SR_WMRD: if (tmr_zero) st_n = ST_SR_AREF;
         ST_SR_AREF: st_n = ST_SR_WRFC;
         ST_SR_WRFC: if (tmr_zero) st_n = ST_SR;
         ST_SR: begin
            if (resid_ok && (acc_req || lp_mode != LPM_SELF)) st_n = ST_WAKE;
         end
         default: st_n = ST_NORM;
      endcase
   end

   // shared timer: loaded on entry to a timed state
   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      if (st_n != st) begin
         unique case (st_n)
            ST_PD, ST_SR: begin tmr_load = 1'b1; tmr_val = TMR_W'(TCKE_EFF - 1); end
            ST_WAKE:      begin tmr_load = 1'b1; tmr_val = TMR_W'(TXP_EFF - 1);  end
            ST_REF,
            ST_SR_AREF:   begin tmr_load = 1'b1; tmr_val = TMR_W'(TRFC - 1);     end
            ST_SR_PALL:   begin tmr_load = 1'b1; tmr_val = TMR_W'(TRP - 1);      end
            ST_SR_MRS:    begin tmr_load = 1'b1; tmr_val = TMR_W'(TMRD - 1);     end
            default:      ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_NORM;
         ref_pend <= 1'b0;
      end else begin
         st <= st_n;
         if (st == ST_REF)
            ref_pend <= 1'b0;
         else if (ref_tick && (st == ST_PD || st == ST_WAKE))
            ref_pend <= 1'b1;
      end
   end

   always_comb begin
      unique case (st)
         ST_SR_PALL:        cmd_e = CMD_PALL;
         ST_SR_MRS:         cmd_e = CMD_MRS;
         ST_REF, ST_SR_AREF: cmd_e = CMD_AREF;
         default:           cmd_e = CMD_NOP;
      endcase
   end

   assign cmd     = cmd_e;
   assign cke     = !(st == ST_PD || st == ST_SR);
   assign busy    = (st != ST_NORM);
   assign track   = (st == ST_NORM);
   assign acc_gnt = (st == ST_NORM) && acc_req;
   assign ba      = (st == ST_SR_MRS) ? BA_W'(2) : '0;
   assign addr    = (st == ST_SR_MRS) ? ext_mode_val : '0;

   // ---------------- assertions ----------------
   logic [31:0] lo_cnt, hi_cnt;
   logic        pall_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_cnt    <= '0;
         hi_cnt    <= '1;
         pall_seen <= 1'b0;
      end else begin
         if (cke) begin
            lo_cnt <= '0;
            if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
         end else begin
            hi_cnt <= '0;
            if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
         end
         if (!busy)                 pall_seen <= 1'b0;
         else if (cmd == CMD_PALL)  pall_seen <= 1'b1;
      end
   end

   a_r6_exit_nop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke) |-> (cmd == CMD_NOP) && busy);

   a_r3_enter_owned: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke) |-> busy && (cmd == CMD_NOP));

   a_r8_cke_min_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke) |-> (lo_cnt >= 32'(TCKE_EFF)));

   a_r7_txp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && cmd != CMD_NOP) |-> (hi_cnt >= 32'(TXP_EFF)));

   a_r9_pall_before_mrs: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_MRS) |-> pall_seen);

   a_r12_cmd_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != CMD_NOP) |-> busy);

   a_r12_gnt_free: assert property (@(posedge clk) disable iff (!rst_n)
      acc_gnt |-> (!busy && cke));

endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq
   import sdram_lp_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int BA_W       = 2,
   parameter int MEM_KIND   = KIND_LPDDR1,
   parameter int TXP        = 3,
   parameter int TCKE       = 4,
   parameter int TRP        = 3,
   parameter int TMRD       = 2,
   parameter int TRFC       = 5,
   parameter int IDLE_SHORT = 64,
   parameter int IDLE_LONG  = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        lp_mode,
   input  logic [1:0]        idle_sel,
   input  logic              acc_req,
   input  logic              ref_tick,
   input  logic [ADDR_W-1:0] ext_mode_val,
   output logic              cke,
   output logic [2:0]        cmd,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr,
   output logic              busy,
   output logic              acc_gnt
);

   localparam int TXP_EFF  = (MEM_KIND == KIND_LPDDR1) ? TXP : 1;
   localparam int TCKE_EFF = (MEM_KIND == KIND_SDR) ? 1 : TCKE;
   localparam int TMR_MAX  = imax(imax(TXP_EFF, TCKE_EFF), imax(imax(TRP, TMRD), TRFC));
   localparam int TMR_W    = $clog2(TMR_MAX + 1);

   initial begin
      assert (MEM_KIND >= KIND_SDR && MEM_KIND <= KIND_DDR2)
         else $error("unknown memory kind");
      assert (TRP >= 2 && TMRD >= 2 && TRFC >= 2)
         else $error("command spacings must be at least 2 cycles");
      assert (TXP >= 1 && TCKE >= 1)
         else $error("exit hold and residency must be at least 1 cycle");
      assert (BA_W >= 2) else $error("bank address too narrow");
   end

   logic             tmr_load, tmr_zero, idle_met, track;
   logic [TMR_W-1:0] tmr_val;

   sdram_lp_timer #(.W(TMR_W)) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   sdram_lp_idle #(.IDLE_SHORT(IDLE_SHORT), .IDLE_LONG(IDLE_LONG)) idle_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .track   (track),
      .acc_req (acc_req),
      .sel     (idle_sel),
      .met     (idle_met)
   );

   sdram_lp_fsm #(
      .ADDR_W   (ADDR_W),
      .BA_W     (BA_W),
      .TMR_W    (TMR_W),
      .TXP_EFF  (TXP_EFF),
      .TCKE_EFF (TCKE_EFF),
      .TRP      (TRP),
      .TMRD     (TMRD),
      .TRFC     (TRFC)
   ) fsm_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .lp_mode      (lp_mode),
      .acc_req      (acc_req),
      .ref_tick     (ref_tick),
      .ext_mode_val (ext_mode_val),
      .idle_met     (idle_met),
      .tmr_zero     (tmr_zero),
      .tmr_load     (tmr_load),
      .tmr_val      (tmr_val),
      .track        (track),
      .cke          (cke),
      .cmd          (cmd),
      .ba           (ba),
      .addr         (addr),
      .busy         (busy),
      .acc_gnt      (acc_gnt)
   );

endmodule

// File: tb/sdram_lp_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_lp_seq_tb_top;

   localparam int TXP = 3, TCKE = 4, TRP = 3, TMRD = 2, TRFC = 5;
   localparam logic [12:0] EMR = 13'h0B3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  lp_mode = 2'b00, idle_sel = 2'b00;
   logic        acc_req = 1'b0, ref_tick = 1'b0;
   logic [12:0] ext_mode_val = EMR;
   logic        cke, busy, acc_gnt;
   logic [2:0]  cmd;
   logic [1:0]  ba;
   logic [12:0] addr;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sdram_lp_seq dut_i (
      .clk(clk), .rst_n(rst_n), .lp_mode(lp_mode), .idle_sel(idle_sel),
      .acc_req(acc_req), .ref_tick(ref_tick), .ext_mode_val(ext_mode_val),
      .cke(cke), .cmd(cmd), .ba(ba), .addr(addr), .busy(busy), .acc_gnt(acc_gnt)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // bring the block back to normal mode with a request held
   task automatic wake_to_normal();
      int n = 0;
      acc_req = 1'b1;
      step();
      while (busy && n < 100) begin n++; step(); end
      step();
   endtask

   task automatic t_reset();
      chk("R1 reset cke", int'(cke), 1);
      chk("R1 reset busy", int'(busy), 0);
      chk("R1 reset cmd", int'(cmd), 0);
      chk("R1 reset ba/addr", int'(ba) + int'(addr), 0);
   endtask

   task automatic t_no_lowpower();
      int bad = 0;
      lp_mode = 2'b00; idle_sel = 2'b00; acc_req = 1'b0;
      for (int i = 0; i < 150; i++) begin
         if (!cke || busy) bad++;
         if (i == 75) lp_mode = 2'b11;
         step();
      end
      chk("R2 modes 00/11 stay awake", bad, 0);
   endtask

   task automatic t_pd_cycle();
      int low, hi, nop_bad;
      acc_req = 1'b1; lp_mode = 2'b10; idle_sel = 2'b00;
      step();
      acc_req = 1'b0;
      step();
      chk("R3 pd cke low", int'(cke), 0);
      chk("R3 pd busy", int'(busy), 1);
      chk("R3 pd cmd nop", int'(cmd), 0);
      acc_req = 1'b1;
      low = 1;
      step();
      while (!cke && low < 50) begin low++; step(); end
      chk("R8 cke low residency", low, TCKE);
      chk("R6 nop on cke rise", int'(cmd), 0);
      hi = 0; nop_bad = 0;
      while (busy && hi < 50) begin
         if (cmd != 3'd0) nop_bad++;
         hi++; step();
      end
      chk("R7 exit nop hold", hi, TXP);
      chk("R7 only nop during hold", nop_bad, 0);
      chk("R12 grant after exit", int'(acc_gnt), 1);
   endtask

   task automatic count_idle(input string tag, input int exp);
      int n = 0;
      while (cke && n < 1000) begin n++; step(); end
      chk(tag, n, exp);
   endtask

   task automatic t_timeout();
      int early;
      wake_to_normal();
      idle_sel = 2'b01; acc_req = 1'b0;
      count_idle("R4 window 64", 64);
      wake_to_normal();
      idle_sel = 2'b10; acc_req = 1'b0;
      count_idle("R4 window 128", 128);
      wake_to_normal();
      idle_sel = 2'b01; acc_req = 1'b0;
      early = 0;
      for (int i = 0; i < 40; i++) begin
         if (!cke) early++;
         step();
      end
      acc_req = 1'b1; step();
      acc_req = 1'b0;
      chk("R4 no entry before restart", early, 0);
      count_idle("R4 restart after request", 64);
   endtask

   task automatic t_refresh();
      int hi, n;
      wake_to_normal();
      idle_sel = 2'b00; acc_req = 1'b0;
      step();
      for (int i = 0; i < 10; i++) step();
      chk("R5 in power-down before tick", int'(cke), 0);
      ref_tick = 1'b1; step(); ref_tick = 1'b0;
      chk("R5 tick wakes memory", int'(cke), 1);
      hi = 0;
      while (cmd == 3'd0 && busy && hi < 50) begin hi++; step(); end
      chk("R5 hold before refresh", hi, TXP);
      chk("R5 auto-refresh issued", int'(cmd), 3);
      n = 0;
      while (busy && n < 50) begin n++; step(); end
      chk("R5 refresh spacing", n, TRFC);
      step();
      chk("R5 back to power-down", int'(cke), 0);
   endtask

   task automatic t_tick_and_access();
      int aref_i = -1, gnt_i = -1;
      for (int i = 0; i < 10; i++) step();
      ref_tick = 1'b1; acc_req = 1'b1;
      step();
      ref_tick = 1'b0;
      for (int i = 0; i < 40; i++) begin
         if (cmd == 3'd3 && aref_i < 0) aref_i = i;
         if (acc_gnt && gnt_i < 0) gnt_i = i;
         step();
      end
      chk("R11 refresh first", aref_i, TXP);
      chk("R11 grant after refresh", gnt_i, TXP + TRFC);
   endtask

   task automatic t_self_refresh();
      int pall_i = -1, mrs_i = -1, aref_i = -1, low_i = -1, bad = 0, hi = 0;
      int mrs_ba = -1, mrs_addr = -1, first_nop = -1;
      lp_mode = 2'b01; idle_sel = 2'b00;
      step();
      acc_req = 1'b0;
      for (int i = 0; i < 60 && low_i < 0; i++) begin
         if (i == 1) first_nop = (cmd == 3'd0 && busy) ? 1 : 0;
         if (cmd == 3'd1 && pall_i < 0) pall_i = i;
         if (cmd == 3'd2 && mrs_i < 0) begin
            mrs_i = i; mrs_ba = int'(ba); mrs_addr = int'(addr);
         end
         if (cmd == 3'd3 && aref_i < 0) aref_i = i;
         if (!cke) low_i = i;
         else step();
      end
      chk("R9 leading nop", first_nop, 1);
      chk("R9 precharge all slot", pall_i, 2);
      chk("R9 mrs after trp", mrs_i - pall_i, TRP);
      chk("R9 mrs bank", mrs_ba, 2);
      chk("R9 mrs value", mrs_addr, int'(EMR));
      chk("R9 refresh after tmrd", aref_i - mrs_i, TMRD);
      chk("R9 cke low after trfc", low_i - aref_i, TRFC);
      ref_tick = 1'b1; step(); ref_tick = 1'b0;
      for (int i = 0; i < 20; i++) begin
         if (cke || cmd != 3'd0) bad++;
         step();
      end
      chk("R10 tick ignored in self refresh", bad, 0);
      acc_req = 1'b1;
      step();
      chk("R10 exit raises cke", int'(cke), 1);
      bad = 0;
      while (busy && hi < 50) begin
         if (cmd != 3'd0) bad++;
         hi++; step();
      end
      chk("R10 exit hold", hi, TXP);
      chk("R10 no refresh on exit", bad, 0);
      chk("R12 grant after self refresh", int'(acc_gnt), 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      step();
      t_reset();
      t_no_lowpower();
      t_pd_cycle();
      t_timeout();
      t_refresh();
      t_tick_and_access();
      t_self_refresh();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule